// File: doc/BRIEF.md
# Serial Expansion Channel Immediate-Transfer Controller

This block is a single channel of a synchronous serial master for an expansion port. Software reaches it through three 32-bit registers: a parameter/status register, a control register and a data register. To talk to a device, software picks one of three device selects and one of eight bit-rate codes. It then loads up to four bytes into the data register and sets the start bit. The channel shifts the chosen number of bytes out on the serial data line, most significant bit first from bit 31. At the same time it captures the incoming line, and every captured bit lands in the position of the bit it replaced.

When the transfer finishes, the channel clears the start bit and raises a transfer-complete status flag. A two-flop synchronizer watches the device-attach pin, and any change on it raises an attach status flag. Each flag has its own enable mask. A mask gates only the shared interrupt output and never stops its flag from being set. Software clears a flag by writing 1 to it.

The serial clock comes from the block clock, which runs at twice the 54 MHz reference. Each half of a bit period lasts 2^(6-code) block cycles. This gives the doubling ladder from 0.84375 MHz (code 0) to 54 MHz (code 6). Code 7 behaves like code 0.

Top module: `sxp_channel`

## Requirements
- R1: After reset all three registers read 0, all chip selects are high (inactive), the serial clock is low and the interrupt output is low.
- R2: The rate code sits in parameter bits [6:4]. Each serial clock high phase (and each low phase) lasts 2^(6-code) clock cycles for codes 0..6, and code 7 gives 64 cycles, the same as code 0.
- R3: Control bits [5:4] hold the byte count minus one. A transfer produces exactly 8*(count) serial clock pulses.
- R4: Each transfer is full-duplex and goes MSB first from data bit 31. The bit sent from data position p is replaced by the bit received in the same period, and data bits below the transfer length keep their values. The type code in control bits [2:1] has no effect.
- R5: Control bit 0 (start) reads 1 from the write that starts a transfer until the transfer completes, and 0 after. While a transfer runs, writes to the data register, the control register and to the rate and select fields are ignored.
- R6: The transfer-complete flag is parameter bit 0. It is set when a transfer completes, and writing 1 to it clears it.
- R7: The interrupt output equals (bit 0 AND mask bit 1) OR (bit 2 AND mask bit 3). A cleared mask never stops a flag from being set.
- R8: The select field is parameter bits [10:8], one bit per device, and drives the active-low chip selects (chip select n low when field bit n is 1). A write that sets more than one select bit leaves the field unchanged.
- R9: Parameter bit 12 reads the synchronized device-present pin. Every change of that pin sets the attach flag (bit 2), and writing 1 to bit 2 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (twice the 54 MHz reference) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 parameter, 1 control, 2 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| dev_present_i | input | 1 | Device attached pin (asynchronous) |
| miso_i | input | 1 | Serial data from device |
| mosi_o | output | 1 | Serial data to device |
| sclk_o | output | 1 | Serial bit clock, low when idle |
| cs_n_o | output | 3 | Active-low device chip selects |
| irq_o | output | 1 | Masked interrupt output |

## Verification
The bench attaches a device model that returns a pattern different from the one sent. A design that shifted LSB first, packed the received bytes at the bottom of the register, or ran one byte too few or too many would show a wrong data word or a wrong pulse count. The bench measures the high phase at rates 6, 5, 4, 0 and 7, so a divider off by a power of two, or one that treats code 7 as a fast rate, gives a wrong width. It writes during a running transfer, where a design without the busy lockout would corrupt the data or restart the transfer. It also drives masked flags and a select write with two bits set, and a design that gated the flag instead of the output, or accepted the illegal select, would be caught.

// File: rtl/sxp_pkg.sv
package sxp_pkg;

    typedef enum logic [1:0] {
        ADR_PARAM = 2'd0,
        ADR_CTRL  = 2'd1,
        ADR_DATA  = 2'd2
    } reg_adr_e;

    localparam int RATE_W   = 3;
    localparam int CS_W     = 3;
    localparam int TYPE_W   = 2;
    localparam int DIV_W    = 6;
    localparam int FAST_CODE = 6;

    // parameter register fields
    localparam int P_TC     = 0;
    localparam int P_TCM    = 1;
    localparam int P_ATT    = 2;
    localparam int P_ATTM   = 3;
    localparam int P_RATE   = 4;
    localparam int P_CS     = 8;
    localparam int P_PRES   = 12;

    // control register fields
    localparam int C_START  = 0;
    localparam int C_TYPE   = 1;
    localparam int C_LEN    = 4;

    // half-period length minus one for a rate code; the reserved code runs slowest
    function automatic logic [DIV_W-1:0] half_limit(input logic [RATE_W-1:0] code);
        logic [DIV_W:0] span;
        if (int'(code) > FAST_CODE) span = (DIV_W+1)'(1) << FAST_CODE;
        else                        span = (DIV_W+1)'(1) << (FAST_CODE - int'(code));
        return DIV_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/sxp_clkdiv.sv
module sxp_clkdiv
    import sxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = half_limit(rate);
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim)); // R2

endmodule

// File: rtl/sxp_shifter.sv
module sxp_shifter #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int LEN_W = $clog2(DATA_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sclk,
    output logic [IDX_W-1:0] bit_idx,
    output logic             wr_en,
    output logic             wr_val,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             phase;
        logic [IDX_W-1:0] bitn;
        logic [IDX_W-1:0] last;
        logic             rx;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_val = q.rx;
        done   = 1'b0;
        if (start && !q.busy) begin
            d.busy  = 1'b1;
            d.phase = 1'b0;
            d.bitn  = '0;
            d.last  = {len, 3'b111};
        end else if (q.busy && tick) begin
            if (!q.phase) begin
                d.phase = 1'b1;
                d.rx    = miso;
            end else begin
                d.phase = 1'b0;
                wr_en   = 1'b1;
                if (q.bitn == q.last) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sclk    = q.busy & q.phase;
    assign bit_idx = q.bitn;

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.bitn <= q.last)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.busy); // R5

endmodule

// File: rtl/sxp_irq.sv
module sxp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_set,
    input  logic tc_clr,
    input  logic att_set,
    input  logic att_clr,
    input  logic tc_mask,
    input  logic att_mask,
    output logic tc_stat,
    output logic att_stat,
    output logic irq
);
    typedef struct packed {
        logic tc;
        logic att;
    } flg_t;

    flg_t d, q;

    always_comb begin
        d.tc  = tc_set  | (q.tc  & ~tc_clr);
        d.att = att_set | (q.att & ~att_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tc_stat  = q.tc;
    assign att_stat = q.att;
    assign irq      = (q.tc & tc_mask) | (q.att & att_mask);

    AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set |=> tc_stat); // R6
    AST_ATT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        att_set |=> att_stat); // R9
    AST_IRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set && tc_mask) |=> (irq || !tc_mask)); // R7

endmodule

// File: rtl/sxp_channel.sv
module sxp_channel
    import sxp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_present_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic              sclk_o,
    output logic [CS_W-1:0]   cs_n_o,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int LEN_W = $clog2(DATA_W / 8);

    typedef struct packed {
        logic [RATE_W-1:0]      rate;
        logic [CS_W-1:0]        cs;
        logic                   tc_mask;
        logic                   att_mask;
        logic [LEN_W-1:0]       len;
        logic [TYPE_W-1:0]      typ;
        logic [DATA_W-1:0]      data;
        logic [SYNC_STAGES-1:0] sync;
        logic                   pres_prev;
    } regs_t;

    regs_t d, q;

    logic             busy, tick, wr_en, wr_val, done, start;
    logic             tc_clr, att_clr, att_set, present, tc_stat, att_stat;
    logic [IDX_W-1:0] bit_idx, pos;
    logic [CS_W-1:0]  cs_req;

    assign present = q.sync[SYNC_STAGES-1];
    assign att_set = present ^ q.pres_prev;
    assign pos     = IDX_W'(DATA_W - 1) - bit_idx;
    assign cs_req  = reg_wdata[P_CS +: CS_W];

    always_comb begin
        d         = q;
        tc_clr    = 1'b0;
        att_clr   = 1'b0;
        start     = 1'b0;
        d.sync      = {q.sync[SYNC_STAGES-2:0], dev_present_i};
        d.pres_prev = present;
        if (reg_wr) begin
            case (reg_adr_e'(reg_addr))
                ADR_PARAM: begin
                    tc_clr     = reg_wdata[P_TC];
                    att_clr    = reg_wdata[P_ATT];
                    d.tc_mask  = reg_wdata[P_TCM];
                    d.att_mask = reg_wdata[P_ATTM];
                    if (!busy) begin
                        d.rate = reg_wdata[P_RATE +: RATE_W];
                        if ($countones(cs_req) <= 1) d.cs = cs_req;
                    end
                end
                ADR_CTRL: begin
                    if (!busy) begin
                        d.len = reg_wdata[C_LEN +: LEN_W];
                        d.typ = reg_wdata[C_TYPE +: TYPE_W];
                        start = reg_wdata[C_START];
                    end
                end
                ADR_DATA: begin
                    if (!busy) d.data = reg_wdata;
                end
                default: ;
            endcase
        end
        if (wr_en) d.data[pos] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sxp_clkdiv u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (q.rate),
        .tick  (tick)
    );

    sxp_shifter #(.DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .len     (reg_wdata[C_LEN +: LEN_W]),
        .tick    (tick),
        .miso    (miso_i),
        .busy    (busy),
        .sclk    (sclk_o),
        .bit_idx (bit_idx),
        .wr_en   (wr_en),
        .wr_val  (wr_val),
        .done    (done)
    );

    sxp_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_set   (done),
        .tc_clr   (tc_clr),
        .att_set  (att_set),
        .att_clr  (att_clr),
        .tc_mask  (q.tc_mask),
        .att_mask (q.att_mask),
        .tc_stat  (tc_stat),
        .att_stat (att_stat),
        .irq      (irq_o)
    );

    assign mosi_o = busy ? q.data[pos] : 1'b0;
    assign cs_n_o = ~q.cs;

    always_comb begin
        reg_rdata = '0;
        case (reg_adr_e'(reg_addr))
            ADR_PARAM: begin
                reg_rdata[P_TC]              = tc_stat;
                reg_rdata[P_TCM]             = q.tc_mask;
                reg_rdata[P_ATT]             = att_stat;
                reg_rdata[P_ATTM]            = q.att_mask;
                reg_rdata[P_RATE +: RATE_W]  = q.rate;
                reg_rdata[P_CS +: CS_W]      = q.cs;
                reg_rdata[P_PRES]            = present;
            end
            ADR_CTRL: begin
                reg_rdata[C_START]           = busy;
                reg_rdata[C_TYPE +: TYPE_W]  = q.typ;
                reg_rdata[C_LEN +: LEN_W]    = q.len;
            end
            ADR_DATA: reg_rdata = q.data;
            default:  ;
        endcase
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q.rate) && $stable(q.cs))); // R5
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk_o); // R1

endmodule

// File: tb/sxp_channel_tb.sv
module sxp_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_present = 1'b0;
    logic        miso, mosi, sclk, irq;
    logic [2:0]  cs_n;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sxp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_present_i(dev_present), .miso_i(miso), .mosi_o(mosi),
        .sclk_o(sclk), .cs_n_o(cs_n), .irq_o(irq)
    );

    // device model: drives MSB first, captures on rising serial clock
    logic [31:0] dev_tx = '0;
    logic [31:0] dev_rx;
    int          dev_idx;
    logic        dev_clr = 1'b0;
    assign miso = (dev_idx < 32) ? dev_tx[31 - dev_idx] : 1'b0;
    always @(posedge sclk or posedge dev_clr) begin
        if (dev_clr) begin dev_idx <= 0; dev_rx <= '0; end
        else begin dev_rx <= {dev_rx[30:0], mosi}; dev_idx <= dev_idx + 1; end
    end

    // high-phase width meter
    int hi_run = 0;
    int last_hi = 0;
    always @(negedge clk) begin
        if (sclk) hi_run <= hi_run + 1;
        else if (hi_run != 0) begin last_hi <= hi_run; hi_run <= 0; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] pval(input logic [2:0] rate, input logic [2:0] cs,
                                         input bit tcm, input bit attm);
        return ({29'd0, cs} << 8) | ({29'd0, rate} << 4) | (32'(attm) << 3) | (32'(tcm) << 1);
    endfunction

    typedef struct {
        logic [31:0] data;
        logic [31:0] drx;
        int          nbits;
    } exp_t;
    exp_t sb_q[$];
    event mon_done;
    bit   sb_on = 1'b0;
    logic [31:0] cur_param = '0;

    // monitor: pops expected results when completion is signalled
    initial begin
        logic [31:0] v;
        exp_t e;
        forever begin
            @(posedge irq);
            if (!sb_on || sb_q.size() == 0) continue;
            e = sb_q.pop_front();
            rd(2'd2, v);
            chk(v == e.data, "R4 data word", v, e.data);
            chk(dev_rx == e.drx, "R4 bits sent", dev_rx, e.drx);
            chk(dev_idx == e.nbits, "R3 pulse count", 32'(dev_idx), 32'(e.nbits));
            rd(2'd1, v);
            chk(v[0] == 1'b0, "R5 start cleared", v, 32'd0);
            rd(2'd0, v);
            chk(v[0] == 1'b1, "R6 flag set", v, 32'd1);
            wr(2'd0, cur_param | 32'd1);
            @(negedge clk);
            chk(irq == 1'b0, "R6 w1c clears", 32'(irq), 32'd0);
            -> mon_done;
        end
    end

    task automatic xfer(input logic [2:0] rate, input logic [1:0] len, input logic [1:0] typ,
                        input logic [31:0] tx, input logic [31:0] devtx, input bit poke, input int hi_exp);
        int n;
        exp_t e;
        logic [31:0] v;
        n = 8 * (int'(len) + 1);
        cur_param = pval(rate, 3'b001, 1'b1, 1'b0);
        wr(2'd0, cur_param);
        wr(2'd2, tx);
        dev_tx = devtx;
        dev_clr = 1'b1; #1 dev_clr = 1'b0;
        for (int i = 0; i < 32; i++) e.data[i] = (i >= 32 - n) ? devtx[i] : tx[i];
        e.drx = tx >> (32 - n);
        e.nbits = n;
        sb_q.push_back(e);
        wr(2'd1, {26'd0, len, 1'b0, typ, 1'b1});
        if (poke) begin
            rd(2'd1, v);
            chk(v[0] == 1'b1, "R5 start reads busy", v, 32'd1);
            wr(2'd2, 32'hDEAD_BEEF);
            wr(2'd1, 32'h0000_0031);
            wr(2'd0, pval(3'd6, 3'b100, 1'b1, 1'b0));
            chk(cs_n == 3'b110, "R5 select frozen", 32'(cs_n), 32'h6);
        end
        @(mon_done);
        @(negedge clk);
        chk(last_hi == hi_exp, "R2 high width", 32'(last_hi), 32'(hi_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        dev_clr = 1'b1; #1 dev_clr = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk(v == 32'd0, "R1 param", v, 32'd0);
        rd(2'd1, v); chk(v == 32'd0, "R1 ctrl", v, 32'd0);
        rd(2'd2, v); chk(v == 32'd0, "R1 data", v, 32'd0);
        chk(cs_n == 3'b111 && !sclk && !irq, "R1 pins", {28'd0, cs_n, irq}, 32'hE);

        // R8 select legality
        wr(2'd0, pval(3'd0, 3'b110, 1'b0, 1'b0));
        rd(2'd0, v); chk(v[10:8] == 3'b000, "R8 two-bit select ignored", v, 32'd0);
        wr(2'd0, pval(3'd0, 3'b010, 1'b0, 1'b0));
        chk(cs_n == 3'b101, "R8 select drives pin", 32'(cs_n), 32'h5);

        // scoreboarded transfers
        sb_on = 1'b1;
        xfer(3'd6, 2'd3, 2'd0, 32'hA5C3_0F96, 32'h3C5A_F00F, 1'b0, 1);
        xfer(3'd6, 2'd0, 2'd1, 32'h1234_5678, 32'hC300_0000, 1'b0, 1);
        xfer(3'd5, 2'd1, 2'd2, 32'hFFFF_0000, 32'h0F0F_FFFF, 1'b0, 2);
        xfer(3'd4, 2'd2, 2'd3, 32'h8001_7E42, 32'h6699_AA55, 1'b1, 4);
        xfer(3'd0, 2'd0, 2'd0, 32'h5500_00AA, 32'hAA00_0000, 1'b0, 64);
        xfer(3'd7, 2'd0, 2'd1, 32'h0F00_0001, 32'hF000_0000, 1'b0, 64);
        sb_on = 1'b0;

        // R7 masked transfer flag
        cur_param = pval(3'd6, 3'b001, 1'b0, 1'b0);
        wr(2'd0, cur_param);
        wr(2'd1, 32'h0000_0001);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk(v[0] == 1'b1, "R7 flag set under mask", v, 32'd1);
        chk(irq == 1'b0, "R7 masked output", 32'(irq), 32'd0);
        cur_param = pval(3'd6, 3'b001, 1'b1, 1'b0);
        wr(2'd0, cur_param);
        chk(irq == 1'b1, "R7 unmask raises output", 32'(irq), 32'd1);
        wr(2'd0, cur_param | 32'd1);
        chk(irq == 1'b0, "R6 clear by write", 32'(irq), 32'd0);

        // R9 attach detection
        cur_param = pval(3'd6, 3'b001, 1'b0, 1'b0);
        wr(2'd0, cur_param);
        dev_present = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk(v[12] == 1'b1 && v[2] == 1'b1, "R9 attach seen", v, 32'h1004);
        chk(irq == 1'b0, "R7 attach masked", 32'(irq), 32'd0);
        cur_param = pval(3'd6, 3'b001, 1'b0, 1'b1);
        wr(2'd0, cur_param);
        chk(irq == 1'b1, "R7 attach unmasked", 32'(irq), 32'd1);
        wr(2'd0, cur_param | 32'd4);
        rd(2'd0, v); chk(v[2] == 1'b0 && irq == 1'b0, "R9 attach flag w1c", v, 32'h1000);
        dev_present = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk(v[12] == 1'b0 && v[2] == 1'b1, "R9 detach seen", v, 32'h4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule